// File: doc/BRIEF.md
# Video Input Mode Discriminator

This block watches the horizontal and vertical sync lines of a computer video source and works out which timing is arriving. It runs on a fixed reference clock and brings both sync inputs into that clock domain itself. For each sync it learns the polarity by comparing how long the line stays high with how long it stays low. It counts lines between frame starts and measures the length of a line in reference clocks.

The polarity pair picks the active-line mode: 480, 400 or 350 lines. A line count at or above a split parameter marks a high-rate scan, about 31.5 kHz with 525 lines per frame. Below the split the scan is low-rate, about 15.7 kHz with 262 lines per frame. A mode is reported valid only once two frames in a row agree. A one-cycle pulse flags each newly confirmed mode. If the frame sync goes quiet, the block drops back to its idle state and starts acquiring again.

Top module: `vmd_discriminator`

## Requirements
- R1: `hsync_neg` (or `vsync_neg`) is 1 when the sync spent longer high than low during its last complete rising-to-rising period, and 0 otherwise.
- R2: At each classified frame, `mode_code` is set from the polarity pair: hsync negative with vsync negative gives 2'd1 (480 lines), hsync negative with vsync positive gives 2'd2 (400 lines), hsync positive with vsync negative gives 2'd3 (350 lines), and both positive gives 2'd0 (unsupported).
- R3: `line_count` holds the number of hsync rising edges seen after one vsync rising edge, up to and including the next vsync rising edge. Counting starts at the first vsync rising edge after reset or timeout.
- R4: `line_period` holds the number of reference clock cycles between the two most recent hsync rising edges.
- R5: `high_rate` is 1 when the classified frame's line count is at least `RATE_SPLIT_LINES`, and 0 otherwise.
- R6: `valid` rises only when two consecutively classified frames give the same rate class and the same polarity pair. It falls at the first classified frame that disagrees with the frame before it. While `valid` stays high, `mode_code` does not change.
- R7: A frame whose polarity pair is unsupported never makes `valid` high, and it clears `valid`.
- R8: `mode_changed` is a single-cycle pulse, issued together with `valid`, when the confirmed mode differs from the last confirmed mode, or when it is the first mode confirmed since reset or timeout. Confirming the same mode again gives no pulse.
- R9: If there is no vsync rising edge for `TIMEOUT_CYCLES` cycles, then `valid`, `mode_code`, `high_rate`, `line_count`, `line_period` and both polarity bits return to 0, and acquisition starts over.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| mode_code | output | 2 | 0 unsupported, 1 480-line, 2 400-line, 3 350-line |
| high_rate | output | 1 | Classified frame is a high-rate scan |
| hsync_neg | output | 1 | Horizontal sync is active-low |
| vsync_neg | output | 1 | Vertical sync is active-low |
| line_count | output | LINE_W | Lines in the last complete frame |
| line_period | output | PERIOD_W | Reference clocks per line |
| valid | output | 1 | Mode confirmed over two frames |
| mode_changed | output | 1 | One-cycle pulse on a new confirmed mode |

## Verification
The assertions assume that each sync level lasts several reference clocks. They also assume that a healthy frame is shorter than the timeout, so a quiet vsync input means the source has really stopped rather than that frames are merely long. The stimulus keeps to these assumptions. Every sync pulse is at least four clocks long. Every frame is about a third of the timeout window. Only the deliberate gap runs past the timeout, by a clear margin. Every line and frame starts on a rising edge, so the counts never depend on when the two syncs happen to line up.

// File: rtl/vmd_pkg.sv
package vmd_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_480  = 2'd1,
    MODE_400  = 2'd2,
    MODE_350  = 2'd3
  } vmd_mode_e;

  // Polarity pair to active-line mode; both positive is not supported.
  function automatic vmd_mode_e mode_of(input logic h_neg, input logic v_neg);
    case ({h_neg, v_neg})
      2'b11:   mode_of = MODE_480;
      2'b10:   mode_of = MODE_400;
      2'b01:   mode_of = MODE_350;
      default: mode_of = MODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vmd_sync.sv
module vmd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/vmd_pol_meter.sv
module vmd_pol_meter #(
  parameter int CNT_W = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic level,
  input  logic rise,
  output logic pol_neg,
  output logic pol_vld
);

  logic [CNT_W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic             seen_q, seen_n, neg_q, neg_n, vld_q, vld_n;

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    seen_n = seen_q;
    neg_n  = neg_q;
    vld_n  = vld_q;
    if (clr) begin
      hi_n = '0; lo_n = '0; seen_n = 1'b0; neg_n = 1'b0; vld_n = 1'b0;
    end else if (rise) begin
      if (seen_q) begin
        neg_n = (hi_q > lo_q);
        vld_n = 1'b1;
      end
      seen_n = 1'b1;
      hi_n   = '0;
      lo_n   = '0;
    end else if (level) begin
      if (hi_q != '1) hi_n = hi_q + 1'b1;
    end else begin
      if (lo_q != '1) lo_n = lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; seen_q <= 1'b0; neg_q <= 1'b0; vld_q <= 1'b0;
    end else begin
      hi_q <= hi_n; lo_q <= lo_n; seen_q <= seen_n; neg_q <= neg_n; vld_q <= vld_n;
    end

  assign pol_neg = neg_q;
  assign pol_vld = vld_q;

endmodule

// File: rtl/vmd_frame_meter.sv
module vmd_frame_meter #(
  parameter int LINE_W         = 11,
  parameter int PERIOD_W       = 16,
  parameter int TIMEOUT_CYCLES = 2000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_rise,
  input  logic                vs_rise,
  output logic [LINE_W-1:0]   line_count,
  output logic [PERIOD_W-1:0] line_period,
  output logic                frame_done,
  output logic                stale
);

  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_LIMIT = TO_W'(TIMEOUT_CYCLES);

  logic [TO_W-1:0]     to_q, to_n;
  logic [LINE_W-1:0]   lcnt_q, lcnt_n, lc_q, lc_n;
  logic [PERIOD_W-1:0] pcnt_q, pcnt_n, per_q, per_n;
  logic                run_q, run_n, done_q, done_n;

  // A vsync edge in the same cycle wins over an expiring timeout.
  assign stale = (to_q == TO_LIMIT) && !vs_rise;

  always_comb begin
    to_n   = to_q;
    lcnt_n = lcnt_q;
    lc_n   = lc_q;
    pcnt_n = pcnt_q;
    per_n  = per_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (vs_rise)        to_n = '0;
    else if (to_q != TO_LIMIT) to_n = to_q + 1'b1;
    if (stale) begin
      lcnt_n = '0; lc_n = '0; pcnt_n = '0; per_n = '0; run_n = 1'b0;
    end else begin
      if (hs_rise) begin
        per_n  = pcnt_q;
        pcnt_n = PERIOD_W'(1);
      end else if (pcnt_q != '1) begin
        pcnt_n = pcnt_q + 1'b1;
      end
      if (vs_rise) begin
        if (run_q) begin
          lc_n   = lcnt_q + LINE_W'(hs_rise);
          done_n = 1'b1;
        end
        run_n  = 1'b1;
        lcnt_n = '0;
      end else if (hs_rise && lcnt_q != '1) begin
        lcnt_n = lcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      to_q <= '0; lcnt_q <= '0; lc_q <= '0; pcnt_q <= '0;
      per_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      to_q <= to_n; lcnt_q <= lcnt_n; lc_q <= lc_n; pcnt_q <= pcnt_n;
      per_q <= per_n; run_q <= run_n; done_q <= done_n;
    end

  assign line_count  = lc_q;
  assign line_period = per_q;
  assign frame_done  = done_q;

endmodule

// File: rtl/vmd_classifier.sv
module vmd_classifier
  import vmd_pkg::*;
#(
  parameter int LINE_W           = 11,
  parameter int RATE_SPLIT_LINES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stale,
  input  logic              frame_done,
  input  logic [LINE_W-1:0] line_count,
  input  logic              h_neg,
  input  logic              h_vld,
  input  logic              v_neg,
  input  logic              v_vld,
  output logic [1:0]        mode_code,
  output logic              high_rate,
  output logic              valid,
  output logic              mode_changed
);

  localparam logic [LINE_W-1:0] SPLIT = LINE_W'(RATE_SPLIT_LINES);

  vmd_mode_e  code_c;
  logic       rate_c;
  logic [2:0] cand_c;
  logic [2:0] prev_q, prev_n, conf_q, conf_n;
  logic       prev_ok_q, prev_ok_n, conf_ok_q, conf_ok_n;
  logic [1:0] code_q, code_n;
  logic       rate_q, rate_n, valid_q, valid_n, chg_q, chg_n;

  always_comb begin
    code_c    = mode_of(h_neg, v_neg);
    rate_c    = (line_count >= SPLIT);
    cand_c    = {rate_c, code_c};
    prev_n    = prev_q;
    prev_ok_n = prev_ok_q;
    conf_n    = conf_q;
    conf_ok_n = conf_ok_q;
    code_n    = code_q;
    rate_n    = rate_q;
    valid_n   = valid_q;
    chg_n     = 1'b0;
    if (stale) begin
      prev_n = '0; prev_ok_n = 1'b0; conf_n = '0; conf_ok_n = 1'b0;
      code_n = '0; rate_n = 1'b0; valid_n = 1'b0;
    end else if (frame_done && h_vld && v_vld) begin
      code_n = code_c;
      rate_n = rate_c;
      if (code_c != MODE_NONE && prev_ok_q && cand_c == prev_q) begin
        valid_n = 1'b1;
        if (!conf_ok_q || cand_c != conf_q) begin
          chg_n     = 1'b1;
          conf_n    = cand_c;
          conf_ok_n = 1'b1;
        end
      end else begin
        valid_n = 1'b0;
      end
      prev_n    = cand_c;
      prev_ok_n = (code_c != MODE_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= '0; prev_ok_q <= 1'b0; conf_q <= '0; conf_ok_q <= 1'b0;
      code_q <= '0; rate_q <= 1'b0; valid_q <= 1'b0; chg_q <= 1'b0;
    end else begin
      prev_q <= prev_n; prev_ok_q <= prev_ok_n; conf_q <= conf_n; conf_ok_q <= conf_ok_n;
      code_q <= code_n; rate_q <= rate_n; valid_q <= valid_n; chg_q <= chg_n;
    end

  assign mode_code    = code_q;
  assign high_rate    = rate_q;
  assign valid        = valid_q;
  assign mode_changed = chg_q;

endmodule

// File: rtl/vmd_discriminator.sv
module vmd_discriminator #(
  parameter int LINE_W           = 11,
  parameter int PERIOD_W         = 16,
  parameter int RATE_SPLIT_LINES = 400,
  parameter int TIMEOUT_CYCLES   = 2000000,
  parameter int SYNC_STAGES      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsync_in,
  input  logic                vsync_in,
  output logic [1:0]          mode_code,
  output logic                high_rate,
  output logic                hsync_neg,
  output logic                vsync_neg,
  output logic [LINE_W-1:0]   line_count,
  output logic [PERIOD_W-1:0] line_period,
  output logic                valid,
  output logic                mode_changed
);

  localparam int CNT_W = LINE_W + PERIOD_W;

  logic [1:0] sync_lv, prev_lv_q, rise;
  logic       stale, frame_done, h_vld, v_vld;

  vmd_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({vsync_in, hsync_in}), .q(sync_lv)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_lv_q <= '0;
    else        prev_lv_q <= sync_lv;

  assign rise = sync_lv & ~prev_lv_q;

  vmd_pol_meter #(.CNT_W(CNT_W)) i_hpol (
    .clk(clk), .rst_n(rst_n), .clr(stale), .level(sync_lv[0]), .rise(rise[0]),
    .pol_neg(hsync_neg), .pol_vld(h_vld)
  );

  vmd_pol_meter #(.CNT_W(CNT_W)) i_vpol (
    .clk(clk), .rst_n(rst_n), .clr(stale), .level(sync_lv[1]), .rise(rise[1]),
    .pol_neg(vsync_neg), .pol_vld(v_vld)
  );

  vmd_frame_meter #(
    .LINE_W(LINE_W), .PERIOD_W(PERIOD_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) i_frame (
    .clk(clk), .rst_n(rst_n), .hs_rise(rise[0]), .vs_rise(rise[1]),
    .line_count(line_count), .line_period(line_period),
    .frame_done(frame_done), .stale(stale)
  );

  vmd_classifier #(
    .LINE_W(LINE_W), .RATE_SPLIT_LINES(RATE_SPLIT_LINES)
  ) i_class (
    .clk(clk), .rst_n(rst_n), .stale(stale), .frame_done(frame_done),
    .line_count(line_count), .h_neg(hsync_neg), .h_vld(h_vld),
    .v_neg(vsync_neg), .v_vld(v_vld), .mode_code(mode_code),
    .high_rate(high_rate), .valid(valid), .mode_changed(mode_changed)
  );

endmodule

// File: rtl/vmd_checker.sv
module vmd_checker #(
  parameter int LINE_W         = 11,
  parameter int TIMEOUT_CYCLES = 2000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_in,
  input logic [1:0]        mode_code,
  input logic [LINE_W-1:0] line_count,
  input logic              valid,
  input logic              mode_changed
);

  localparam int QW = $clog2(TIMEOUT_CYCLES + 16) + 1;
  localparam logic [QW-1:0] Q_LIMIT = QW'(TIMEOUT_CYCLES + 4);

  logic [QW-1:0] quiet_q;
  logic          vs_d_q;

  // Cycles since the raw frame sync last changed level.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      quiet_q <= '0;
      vs_d_q  <= 1'b0;
    end else begin
      vs_d_q <= vsync_in;
      if (vsync_in != vs_d_q)   quiet_q <= '0;
      else if (quiet_q != '1)   quiet_q <= quiet_q + 1'b1;
    end

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |=> !mode_changed);

  p_chg_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> valid);

  p_supported_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> mode_code != 2'd0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid)) |-> $stable(mode_code));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q > Q_LIMIT) |-> (!valid && line_count == '0));

endmodule

bind vmd_discriminator vmd_checker #(
  .LINE_W(LINE_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) i_vmd_checker (
  .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .mode_code(mode_code),
  .line_count(line_count), .valid(valid), .mode_changed(mode_changed)
);

// File: tb/test_vmd_discriminator.sv
`timescale 1ns/1ps
module test_vmd_discriminator;

  localparam int LINE_W = 11;
  localparam int PERIOD_W = 16;
  localparam int SPLIT = 18;
  localparam int TIMEOUT = 3000;

  logic clk, rst_n, hs, vs;
  logic [1:0] mode_code;
  logic high_rate, hsync_neg, vsync_neg, valid, mode_changed;
  logic [LINE_W-1:0] line_count;
  logic [PERIOD_W-1:0] line_period;

  int checks = 0, errors = 0, chg_seen = 0;
  // reference model state
  int edges = 0, exp_lc = 0, exp_code = 0, exp_chg = 0;
  int prev_cand = 0, conf = 0;
  bit exp_valid = 0, exp_rate = 0, prev_ok = 0, conf_ok = 0;
  bit l_hn = 0, l_vn = 0;
  int l_nl = 0;

  vmd_discriminator #(
    .LINE_W(LINE_W), .PERIOD_W(PERIOD_W), .RATE_SPLIT_LINES(SPLIT),
    .TIMEOUT_CYCLES(TIMEOUT), .SYNC_STAGES(2)
  ) i_vmd_discriminator (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
    .mode_code(mode_code), .high_rate(high_rate), .hsync_neg(hsync_neg),
    .vsync_neg(vsync_neg), .line_count(line_count), .line_period(line_period),
    .valid(valid), .mode_changed(mode_changed)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  always @(negedge clk) if (rst_n && mode_changed) chg_seen++;

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int code_of(input bit hn, input bit vn);
    if (hn && vn) return 1;
    if (hn) return 2;
    if (vn) return 3;
    return 0;
  endfunction

  // model of one classification of the frame that just ended
  task automatic model_classify(input bit hn, input bit vn, input int nl);
    int cand;
    exp_rate = (nl >= SPLIT);
    exp_code = code_of(hn, vn);
    exp_lc   = nl;
    cand     = exp_rate * 4 + exp_code;
    if (exp_code != 0 && prev_ok && cand == prev_cand) begin
      exp_valid = 1;
      if (!conf_ok || cand != conf) begin
        exp_chg++;
        conf = cand;
        conf_ok = 1;
      end
    end else begin
      exp_valid = 0;
    end
    prev_cand = cand;
    prev_ok = (exp_code != 0);
  endtask

  task automatic send_frame(input bit hn, input bit vn, input int nl, input int hp);
    int total, t;
    total = nl * hp;
    edges++;
    if (edges >= 2) model_classify(l_hn, l_vn, l_nl);
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < hp; c++) begin
        t = l * hp + c;
        if (l == 10 && c == 0) begin
          chk("R6", "valid", int'(valid), int'(exp_valid));
          chk("R2", "mode_code", int'(mode_code), exp_code);
          chk("R3", "line_count", int'(line_count), exp_lc);
          chk("R5", "high_rate", int'(high_rate), int'(exp_rate));
          chk("R8", "mode_changed pulses", chg_seen, exp_chg);
          chk("R1", "hsync_neg", int'(hsync_neg), int'(hn));
          chk("R4", "line_period", int'(line_period), hp);
          if (edges >= 2) chk("R1", "vsync_neg", int'(vsync_neg), int'(l_vn));
        end
        hs = hn ? (c < hp - 4) : (c < 4);
        vs = vn ? (t < total - 2 * hp) : (t < 2 * hp);
        @(negedge clk);
      end
    end
    l_hn = hn; l_vn = vn; l_nl = nl;
  endtask

  // frame types: hneg, vneg, lines, period
  task automatic fa(); send_frame(1, 1, 24, 40); endtask  // 480 high rate
  task automatic fb(); send_frame(1, 0, 24, 40); endtask  // 400 high rate
  task automatic fc(); send_frame(0, 1, 12, 80); endtask  // 350 low rate
  task automatic fd(); send_frame(1, 1, 12, 80); endtask  // 480 low rate
  task automatic fu(); send_frame(0, 0, 24, 40); endtask  // unsupported

  initial begin
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "valid", int'(valid), 0);
    chk("R10", "mode_code", int'(mode_code), 0);
    chk("R10", "line_count", int'(line_count), 0);
    chk("R10", "line_period", int'(line_period), 0);
    chk("R10", "pol bits", int'({hsync_neg, vsync_neg, high_rate, mode_changed}), 0);

    repeat (4) fa();
    repeat (3) fb();
    repeat (3) fc();
    repeat (2) fd();
    repeat (3) fu();   // R7: unsupported pair
    repeat (3) fa();
    fb(); fa(); fb(); fa();   // R6: alternating frames never confirm

    // R9: frame sync goes quiet past the timeout
    hs = 1'b0; vs = 1'b0;
    repeat (TIMEOUT + 1000) @(negedge clk);
    edges = 0; exp_valid = 0; exp_code = 0; exp_rate = 0; exp_lc = 0;
    prev_ok = 0; conf_ok = 0;
    chk("R9", "valid", int'(valid), 0);
    chk("R9", "line_count", int'(line_count), 0);
    chk("R9", "line_period", int'(line_period), 0);
    chk("R9", "mode_code", int'(mode_code), 0);
    chk("R9", "pol bits", int'({hsync_neg, vsync_neg, high_rate}), 0);

    repeat (3) fa();   // R8: same mode after timeout pulses again
    fa();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule